// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Fill, Freeze and Bypass Modes

This block sits between a processor's instruction fetch port and a wide, read-only backing memory. Each cache line holds eight 32-bit instructions. The memory port is as wide as a line, so one transfer refills a complete line. A lookup that hits returns the instruction in the same cycle as the request. A lookup that misses sends one line-aligned read to the backing memory and returns the requested word in the cycle the line arrives.

A 3-bit mode input controls how misses treat the stored contents. In fill mode a miss writes the line into the cache. In freeze mode hits are served as usual, but a miss reads memory without touching tags, data or valid bits. In bypass mode every access goes to memory and the stored contents stay as they are. Changing the mode never discards a line that is already stored.

After program memory has been rewritten, software removes stale lines through two write strobes. The first loads a start byte address. The second loads a word count and starts a walker. The walker visits one line per cycle across the addressed byte range. While it runs, new lookups wait.

Top module: `ifetch_cache`

## Requirements
- R1: After reset every line is invalid, `inv_busy`, `m_req` and `f_ready` are low, and the first fetch of any address is a miss.
- R2: Address split: bits [4:0] are the byte offset within the line, bits [4:2] select the word (word 0 is `m_rdata[31:0]`, word 7 is `m_rdata[255:224]`), the next IDX_W bits are the line index and the remaining upper bits are the tag. Fetch addresses are word aligned.
- R3: A fetch that finds a valid line with a matching tag, in a mode other than bypass, raises `f_ready` in the same cycle as `f_req` with the stored word, and issues no memory request.
- R4: A miss raises `m_req` for exactly one cycle, in the cycle the request is looked up, with `m_addr` set to the line address (low 5 bits zero). `f_ready` rises in the cycle `m_valid` is high, carrying the selected word of `m_rdata`. With a 2-cycle memory, this is two cycles after the request.
- R5: Codes 3'b010 and 3'b000 are fill mode: a miss stores the returned line, and a later fetch to that line hits.
- R6: Code 3'b011 is freeze mode: hits are served, and a miss returns memory data but leaves every line unchanged. The line already stored at that index keeps hitting, and the missed address misses again.
- R7: Code 3'b100 and every reserved code (3'b001, 3'b101, 3'b110, 3'b111) are bypass mode: every fetch misses, and no line is written.
- R8: Switching modes does not invalidate any stored line.
- R9: A write on `inv_cnt_we` with a nonzero word count C invalidates every valid line whose address lies in the byte range [S, S+4C), where S is the last value written through `inv_addr_we`. `inv_busy` is high for exactly the number of lines that range touches, starting in the cycle after the write.
- R10: While `inv_busy` is high, a pending fetch gets neither `f_ready` nor `m_req`. It is looked up in the first cycle after `inv_busy` falls.
- R11: A line outside the invalidated range, or a line at an index inside the range but holding a different tag, stays valid.
- R12: A count write with value zero, or any count write made while `inv_busy` is high, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Cache mode code |
| f_req | input | 1 | Fetch request, held until `f_ready` |
| f_addr | input | ADDR_W | Fetch byte address, word aligned, held with `f_req` |
| f_ready | output | 1 | Fetch completes this cycle |
| f_rdata | output | WORD_W | Fetched instruction |
| m_req | output | 1 | One-cycle line read request |
| m_addr | output | ADDR_W | Line-aligned read address |
| m_rdata | input | WORD_W*LINE_WORDS | Returned line |
| m_valid | input | 1 | `m_rdata` is valid this cycle |
| inv_addr_we | input | 1 | Load the invalidate start address |
| inv_addr_wdata | input | ADDR_W | Invalidate start byte address |
| inv_cnt_we | input | 1 | Load the word count and start invalidation |
| inv_cnt_wdata | input | CNT_W | Number of 32-bit words to invalidate |
| inv_busy | output | 1 | Invalidation walk in progress |

## Verification
A corrupted valid bit or tag shows at the ports on the next fetch to that line, in the request cycle itself. `m_req` appears where none was expected, or `f_ready` rises two cycles late, or it rises at once with stale data. A wrong walker count or start line shows as `inv_busy` staying high for the wrong number of cycles. It also shows as a hit or miss mismatch on the first fetch after the walk. The bench's reference model predicts `f_ready`, `m_req` and the data in every cycle of every fetch, so such a fault is reported in the cycle it first becomes visible.

// File: rtl/ifc_pkg.sv
// Shared types for the instruction cache: decoded mode and its decoder.
// Assumes the 3-bit mode code may change at any cycle.
package ifc_pkg;

    typedef enum logic [1:0] {
        CM_FILL   = 2'd0,
        CM_FREEZE = 2'd1,
        CM_BYPASS = 2'd2
    } cmode_e;

    // Map a raw mode code onto the three behaviours; reserved codes bypass.
    function automatic cmode_e cmode_decode(input logic [2:0] code);
        case (code)
            3'b000, 3'b010: return CM_FILL;
            3'b011:         return CM_FREEZE;
            default:        return CM_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/ifc_store.sv
// Line storage: valid bits, tags and line data, one entry per index.
// Read port is combinational. Fill writes one entry. The clear port drops a
// valid bit only when the stored tag matches. Fill and clear never coincide.
module ifc_store #(
    parameter int NLINES = 1024,
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 17,
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              fill_we,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [TAG_W-1:0]  clr_tag
);

    logic [NLINES-1:0] valid_q;
    logic [TAG_W-1:0]  tag_q  [NLINES];
    logic [LINE_W-1:0] line_q [NLINES];

    // Valid bits: cleared on reset, set by fills, dropped by tag-matched clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (fill_we)
                valid_q[fill_idx] <= 1'b1;
            if (clr_en && (tag_q[clr_idx] == clr_tag))
                valid_q[clr_idx] <= 1'b0;
        end
    end

    // Tag and data arrays: written only by a line fill, never reset.
    always_ff @(posedge clk) begin
        if (fill_we) begin
            tag_q[fill_idx]  <= fill_tag;
            line_q[fill_idx] <= fill_line;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = line_q[rd_idx];

    AST_FILL_CLR_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_we && clr_en)); // R9

endmodule

// File: rtl/ifc_inval.sv
// Invalidate walker. It holds the start address and, on a nonzero word-count
// write while idle, walks every line the byte range touches, one per cycle.
// Assumes the start address is written at least one cycle before the count.
module ifc_inval #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int IDX_W  = 10,
    parameter int CNT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_we,
    input  logic [ADDR_W-1:0]       start_wdata,
    input  logic                    cnt_we,
    input  logic [CNT_W-1:0]        cnt_wdata,
    output logic                    busy,
    output logic [IDX_W-1:0]        clr_idx,
    output logic [ADDR_W-OFF_W-IDX_W-1:0] clr_tag
);

    localparam int LN_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] start_q;
    logic [LN_W-1:0]   cur_line_q;
    logic [ADDR_W:0]   remain_q;
    logic [ADDR_W:0]   end_byte;
    logic [ADDR_W:0]   n_lines;
    logic              go;

    // Number of lines spanned by [start, start + 4*count).
    always_comb begin
        end_byte = {1'b0, start_q}
                 + {{(ADDR_W-1-CNT_W){1'b0}}, cnt_wdata, 2'b00}
                 - (ADDR_W+1)'(1);
        n_lines  = (end_byte >> OFF_W) - ({1'b0, start_q} >> OFF_W) + (ADDR_W+1)'(1);
    end

    assign go = cnt_we && (cnt_wdata != '0) && !busy;

    // Start register, walk pointer and remaining-line counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q    <= '0;
            cur_line_q <= '0;
            remain_q   <= '0;
            busy       <= 1'b0;
        end else begin
            if (start_we)
                start_q <= start_wdata;
            if (busy) begin
                cur_line_q <= cur_line_q + LN_W'(1);
                remain_q   <= remain_q - (ADDR_W+1)'(1);
                busy       <= (remain_q != (ADDR_W+1)'(1));
            end else if (go) begin
                cur_line_q <= start_q[ADDR_W-1:OFF_W];
                remain_q   <= n_lines;
                busy       <= 1'b1;
            end
        end
    end

    assign clr_idx = cur_line_q[IDX_W-1:0];
    assign clr_tag = cur_line_q[LN_W-1:IDX_W];

    AST_INV_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cnt_we && cnt_wdata != '0)) |=> !busy); // R12
    AST_INV_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remain_q != '0)); // R9

endmodule

// File: rtl/ifc_fetch.sv
// Fetch controller: hit detection, miss launch and line-fill sequencing.
// Assumes f_req and f_addr stay stable until f_ready, and that exactly one
// m_valid answers each m_req. The mode at miss launch decides the fill.
module ifc_fetch
    import ifc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int OFF_W      = 5,
    parameter int IDX_W      = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   mode,
    input  logic                         f_req,
    input  logic [ADDR_W-1:0]            f_addr,
    output logic                         f_ready,
    output logic [WORD_W-1:0]            f_rdata,
    output logic                         m_req,
    output logic [ADDR_W-1:0]            m_addr,
    input  logic [WORD_W*LINE_WORDS-1:0] m_rdata,
    input  logic                         m_valid,
    input  logic                         busy,
    input  logic                         inv_cmd,
    output logic [IDX_W-1:0]             rd_idx,
    input  logic                         hit_valid,
    input  logic [ADDR_W-OFF_W-IDX_W-1:0] hit_tag,
    input  logic [WORD_W*LINE_WORDS-1:0] hit_line,
    output logic                         fill_we,
    output logic [IDX_W-1:0]             fill_idx,
    output logic [ADDR_W-OFF_W-IDX_W-1:0] fill_tag
);

    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int BYTE_W = OFF_W - WSEL_W;
    localparam int LN_W   = ADDR_W - OFF_W;

    typedef enum logic {S_LOOK, S_WAIT} fstate_e;

    fstate_e           state_q;
    logic [LN_W-1:0]   miss_line_q;
    logic [WSEL_W-1:0] miss_wsel_q;
    logic              fill_ok_q;
    logic              look, hit, miss;
    logic [WSEL_W-1:0] req_wsel;
    cmode_e            md;

    logic [WORD_W-1:0] hit_words [LINE_WORDS];
    logic [WORD_W-1:0] mem_words [LINE_WORDS];

    // Split both lines into words for the word selectors.
    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_words
        assign hit_words[g] = hit_line[g*WORD_W +: WORD_W];
        assign mem_words[g] = m_rdata[g*WORD_W +: WORD_W];
    end

    assign md       = cmode_decode(mode);
    assign rd_idx   = f_addr[OFF_W+IDX_W-1:OFF_W];
    assign req_wsel = f_addr[OFF_W-1:BYTE_W];

    // Lookup decision for a new request; stalled while the walker runs.
    always_comb begin
        look = (state_q == S_LOOK) && f_req && !busy;
        hit  = look && (md != CM_BYPASS) && hit_valid
             && (hit_tag == f_addr[ADDR_W-1:OFF_W+IDX_W]);
        miss = look && !hit;
    end

    assign m_req    = miss;
    assign m_addr   = {f_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign f_ready  = hit || ((state_q == S_WAIT) && m_valid);
    assign f_rdata  = hit ? hit_words[req_wsel] : mem_words[miss_wsel_q];
    assign fill_we  = (state_q == S_WAIT) && m_valid && fill_ok_q && !busy && !inv_cmd;
    assign fill_idx = miss_line_q[IDX_W-1:0];
    assign fill_tag = miss_line_q[LN_W-1:IDX_W];

    // Miss sequencer: capture the missed address, wait for the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_LOOK;
            miss_line_q <= '0;
            miss_wsel_q <= '0;
            fill_ok_q   <= 1'b0;
        end else begin
            case (state_q)
                S_LOOK: if (miss) begin
                    state_q     <= S_WAIT;
                    miss_line_q <= f_addr[ADDR_W-1:OFF_W];
                    miss_wsel_q <= req_wsel;
                    fill_ok_q   <= (md == CM_FILL);
                end
                default: if (m_valid) state_q <= S_LOOK;
            endcase
        end
    end

    AST_MREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |=> !m_req); // R4
    AST_MISS_WAITS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !m_valid) |-> !f_ready); // R4
    AST_STALL_WHILE_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q == S_LOOK) |-> (!f_ready && !m_req)); // R10
    AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        f_req |-> (f_addr[BYTE_W-1:0] == '0)); // R2

endmodule

// File: rtl/ifetch_cache.sv
// Top of the direct-mapped instruction cache. Connects the line store, the
// fetch controller and the invalidate walker. Capacity, address, word and
// line widths are parameters. The line count must be a power of two.
module ifetch_cache #(
    parameter int ADDR_W      = 32,
    parameter int WORD_W      = 32,
    parameter int LINE_WORDS  = 8,
    parameter int CACHE_BYTES = 32768,
    parameter int CNT_W       = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   mode,
    input  logic                         f_req,
    input  logic [ADDR_W-1:0]            f_addr,
    output logic                         f_ready,
    output logic [WORD_W-1:0]            f_rdata,
    output logic                         m_req,
    output logic [ADDR_W-1:0]            m_addr,
    input  logic [WORD_W*LINE_WORDS-1:0] m_rdata,
    input  logic                         m_valid,
    input  logic                         inv_addr_we,
    input  logic [ADDR_W-1:0]            inv_addr_wdata,
    input  logic                         inv_cnt_we,
    input  logic [CNT_W-1:0]             inv_cnt_wdata,
    output logic                         inv_busy
);

    localparam int LINE_W     = WORD_W * LINE_WORDS;
    localparam int LINE_BYTES = LINE_W / 8;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int NLINES     = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W      = $clog2(NLINES);
    localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;

    logic [IDX_W-1:0]  rd_idx, fill_idx, clr_idx;
    logic [TAG_W-1:0]  rd_tag, fill_tag, clr_tag;
    logic              rd_valid, fill_we;
    logic [LINE_W-1:0] rd_line;
    logic              inv_cmd;

    assign inv_cmd = inv_cnt_we && (inv_cnt_wdata != '0);

    ifc_store #(
        .NLINES (NLINES),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_line   (rd_line),
        .fill_we   (fill_we),
        .fill_idx  (fill_idx),
        .fill_tag  (fill_tag),
        .fill_line (m_rdata),
        .clr_en    (inv_busy),
        .clr_idx   (clr_idx),
        .clr_tag   (clr_tag)
    );

    ifc_fetch #(
        .ADDR_W     (ADDR_W),
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS),
        .OFF_W      (OFF_W),
        .IDX_W      (IDX_W)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .f_req     (f_req),
        .f_addr    (f_addr),
        .f_ready   (f_ready),
        .f_rdata   (f_rdata),
        .m_req     (m_req),
        .m_addr    (m_addr),
        .m_rdata   (m_rdata),
        .m_valid   (m_valid),
        .busy      (inv_busy),
        .inv_cmd   (inv_cmd),
        .rd_idx    (rd_idx),
        .hit_valid (rd_valid),
        .hit_tag   (rd_tag),
        .hit_line  (rd_line),
        .fill_we   (fill_we),
        .fill_idx  (fill_idx),
        .fill_tag  (fill_tag)
    );

    ifc_inval #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) u_inval (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_we    (inv_addr_we),
        .start_wdata (inv_addr_wdata),
        .cnt_we      (inv_cnt_we),
        .cnt_wdata   (inv_cnt_wdata),
        .busy        (inv_busy),
        .clr_idx     (clr_idx),
        .clr_tag     (clr_tag)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!inv_busy && !m_req)); // R1

endmodule

// File: tb/ifetch_cache_tb.sv
// Bench: behavioural reference model of lines, tags and generations, a
// 2-cycle wide memory, and per-cycle comparison of f_ready, m_req and data.
module ifetch_cache_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   mode = 3'b010;
    logic         f_req = 1'b0;
    logic [31:0]  f_addr = '0;
    logic         f_ready;
    logic [31:0]  f_rdata;
    logic         m_req;
    logic [31:0]  m_addr;
    logic [255:0] m_rdata;
    logic         m_valid;
    logic         inv_addr_we = 1'b0;
    logic [31:0]  inv_addr_wdata = '0;
    logic         inv_cnt_we = 1'b0;
    logic [15:0]  inv_cnt_wdata = '0;
    logic         inv_busy;

    int n_chk = 0;
    int n_err = 0;
    int gen   = 0;

    // Reference model state, one entry per index.
    bit          mv [1024];
    logic [31:0] mt [1024];
    int          mg [1024];

    always #4 clk = ~clk;

    ifetch_cache u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .f_req(f_req), .f_addr(f_addr),
        .f_ready(f_ready), .f_rdata(f_rdata), .m_req(m_req), .m_addr(m_addr),
        .m_rdata(m_rdata), .m_valid(m_valid), .inv_addr_we(inv_addr_we),
        .inv_addr_wdata(inv_addr_wdata), .inv_cnt_we(inv_cnt_we),
        .inv_cnt_wdata(inv_cnt_wdata), .inv_busy(inv_busy)
    );

    function automatic logic [31:0] memword(logic [31:0] la, int w, int g);
        return la ^ (32'(w) << 20) ^ (32'(g) * 32'h01000193) ^ 32'h5A5A0000;
    endfunction

    // Backing memory: answers a request two cycles later with a whole line.
    logic        d1_v, d2_v;
    logic [31:0] d1_a, d2_a;
    always @(posedge clk) begin
        if (!rst_n) begin
            d1_v <= 1'b0; d2_v <= 1'b0; d1_a <= '0; d2_a <= '0;
        end else begin
            d1_v <= m_req; d1_a <= m_addr; d2_v <= d1_v; d2_a <= d1_a;
        end
    end
    assign m_valid = d2_v;
    always_comb begin
        for (int w = 0; w < 8; w++)
            m_rdata[w*32 +: 32] = memword(d2_a, w, gen);
    end

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic bit fills(logic [2:0] m);
        return (m == 3'b010) || (m == 3'b000);
    endfunction

    // One fetch; stall = cycles expected blocked by a running walk.
    task automatic fetch(logic [31:0] a, int stall, string rq);
        int idx = int'((a >> 5) % 1024);
        logic [31:0] tg = a >> 15;
        bit byp = !(fills(mode) || mode == 3'b011);
        bit hit = !byp && mv[idx] && (mt[idx] == tg);
        int lat = hit ? 0 : 2;
        logic [31:0] la = a & ~32'h1F;
        logic [31:0] expd = memword(la, int'((a >> 2) & 7), hit ? mg[idx] : gen);
        @(negedge clk);
        f_req = 1'b1; f_addr = a;
        for (int i = 0; i <= stall + lat; i++) begin
            if (i > 0) @(negedge clk);
            #2;
            chk(rq, "f_ready", 32'(f_ready), 32'(i == stall + lat));
            chk(rq, "m_req", 32'(m_req), 32'(!hit && i == stall));
            if (!hit && i == stall) chk(rq, "m_addr", m_addr, la);
            if (i == stall + lat) chk(rq, "f_rdata", f_rdata, expd);
        end
        @(posedge clk); #1 f_req = 1'b0;
        if (!hit && fills(mode)) begin
            mv[idx] = 1'b1; mt[idx] = tg; mg[idx] = gen;
        end
    endtask

    function automatic int span(logic [31:0] s, int c);
        if (c == 0) return 0;
        return int'(((s + 32'(4*c) - 1) >> 5) - (s >> 5)) + 1;
    endfunction

    function automatic void model_inval(logic [31:0] s, int c);
        for (int i = 0; i < span(s, c); i++) begin
            logic [31:0] ln = (s >> 5) + 32'(i);
            int idx = int'(ln % 1024);
            if (mv[idx] && mt[idx] == (ln >> 10)) mv[idx] = 1'b0;
        end
    endfunction

    // Invalidate and count busy cycles; the count write lands in cycle k.
    task automatic inval(logic [31:0] s, int c, string rq);
        int n = span(s, c);
        @(negedge clk); inv_addr_we = 1'b1; inv_addr_wdata = s;
        @(negedge clk); inv_addr_we = 1'b0; inv_cnt_we = 1'b1; inv_cnt_wdata = 16'(c);
        @(negedge clk); inv_cnt_we = 1'b0;
        for (int i = 0; i <= n; i++) begin
            if (i > 0) @(negedge clk);
            #2 chk(rq, "inv_busy", 32'(inv_busy), 32'(i < n));
        end
        model_inval(s, c);
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin mv[i] = 0; mt[i] = '0; mg[i] = 0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk("R1", "f_ready", 32'(f_ready), 0);
        chk("R1", "m_req", 32'(m_req), 0);
        chk("R1", "inv_busy", 32'(inv_busy), 0);

        // R1 first access misses; R2 word select; R3 hit timing; R5 fill
        fetch(32'h1000, 0, "R1");
        fetch(32'h1004, 0, "R3");
        fetch(32'h101C, 0, "R2");
        fetch(32'h1020, 0, "R4");
        fetch(32'h1040, 0, "R4");
        fetch(32'h1060, 0, "R4");
        fetch(32'h1080, 0, "R4");
        fetch(32'h1044, 0, "R5");
        mode = 3'b000;
        fetch(32'h3000, 0, "R5");
        fetch(32'h3008, 0, "R5");

        // R6 freeze: conflicting miss leaves the stored line in place
        mode = 3'b011;
        fetch(32'h1004, 0, "R6");
        fetch(32'h9000, 0, "R6");
        fetch(32'h9000, 0, "R6");
        fetch(32'h1000, 0, "R6");

        // R7 bypass and reserved codes always miss
        mode = 3'b100;
        fetch(32'h1000, 0, "R7");
        fetch(32'h1000, 0, "R7");
        mode = 3'b111;
        fetch(32'h1040, 0, "R7");
        mode = 3'b001;
        fetch(32'h1040, 0, "R7");

        // R8 contents survive mode changes
        mode = 3'b010;
        fetch(32'h1000, 0, "R8");
        fetch(32'h1040, 0, "R8");

        // R9 memory rewritten: stale until invalidated
        gen = 1;
        fetch(32'h1020, 0, "R9");
        inval(32'h1024, 16, "R9");
        fetch(32'h1000, 0, "R11");
        fetch(32'h1020, 0, "R9");
        fetch(32'h1048, 0, "R9");
        fetch(32'h1060, 0, "R9");
        fetch(32'h1080, 0, "R11");

        // R11 same index, different tag stays valid
        fetch(32'h9000, 0, "R11");
        inval(32'h1000, 8, "R11");
        fetch(32'h9000, 0, "R11");

        // R12 zero count does nothing
        inval(32'h9000, 0, "R12");
        fetch(32'h9000, 0, "R12");

        // R10 stall during walk; R12 count write while busy ignored
        fetch(32'h2000, 0, "R10");
        gen = 2;
        @(negedge clk); inv_addr_we = 1'b1; inv_addr_wdata = 32'h1020;
        @(negedge clk); inv_addr_we = 1'b0; inv_cnt_we = 1'b1; inv_cnt_wdata = 16'd32;
        @(negedge clk); inv_cnt_we = 1'b0; inv_addr_we = 1'b1; inv_addr_wdata = 32'h2000;
        #2 chk("R10", "inv_busy", 32'(inv_busy), 1);
        @(negedge clk); inv_addr_we = 1'b0; inv_cnt_we = 1'b1; inv_cnt_wdata = 16'd8;
        #2 chk("R12", "inv_busy", 32'(inv_busy), 1);
        @(posedge clk); #1 inv_cnt_we = 1'b0;
        model_inval(32'h1020, 32);
        fetch(32'h1040, 2, "R10");
        fetch(32'h2000, 0, "R12");
        fetch(32'h1080, 0, "R9");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule